// File: doc/BRIEF.md
# Lane Alignment Sequence Checker and Configuration Extractor

This block sits behind the character decoder of a high-speed serial converter lane. It takes one decoded character per clock, together with a link-state input supplied by the link controller, and watches the lane alignment sequence that runs between code-group synchronisation and user data. The sequence is made of four multiframes. Each multiframe opens with a control start marker and closes with a control alignment marker, and its length in characters comes from a runtime input.

The second multiframe carries a block of configuration octets. The block unpacks these octets into a record of link parameters and compares their arithmetic sum with the checksum octet that ends the block. It reports what it finds on four flags:
- unexpected character: a framing or character fault.
- bad checksum: the configuration sum does not match.
- error: either of the two faults above.
- finished: the whole sequence was clean and the link has moved to user data.

All fault flags are sticky until the link controller sends the link back to its idle state. The captured configuration record is held for the rest of the link's life.

Top module: `alnseq_parser`

## Requirements
- R1: A synchronous active-high reset clears all four flags, the multiframe position and count, and every field of the configuration record, which reads as all zeros.
- R2: The link-state encoding is 0 idle, 1 synchronisation, 2 alignment and 3 user data. In alignment, position 0 of each multiframe must hold a K-flagged 0x1C and position mf_len-1 must hold a K-flagged 0x7C. If either marker is missing or misplaced, error and unexpected-character rise on the following cycle.
- R3: A K-flagged character at a position inside a multiframe, or any character with its disparity or not-in-table flag set, raises error and unexpected-character on the following cycle.
- R4: In multiframe index 1 (counting from 0), positions 1 to 14 are configuration octets 0 to 13, unpacked as follows:
  - octet 0: device id.
  - octet 1: adjust count [7:4] and bank id [3:0].
  - octet 2: adjust direction bit 6, phase adjust bit 5 and lane id [4:0].
  - octet 3: scrambling bit 7 and lane count [4:0].
  - octet 4: octets per frame.
  - octet 5: frames per multiframe [4:0].
  - octet 6: converter count.
  - octet 7: control bits [7:6] and resolution [4:0].
  - octet 8: subclass [7:5] and sample width [4:0].
  - octet 9: version [7:5] and samples per frame [4:0].
  - octet 10: high density bit 7 and control words [4:0].
  - octets 11 and 12: not decoded.
  - octet 13: checksum.

  All bits not named above are ignored. cfg_o is the package record lane_cfg_t packed with the device id in the top byte and the checksum in the bottom byte.
- R5: The full record is visible on cfg_o on the cycle after the K-flagged 0x7C that closes multiframe 1. It then stays unchanged through the later multiframes and through user data.
- R6: At the marker that closes multiframe 1, the sum modulo 256 of all decoded fields except the checksum is compared with octet 13. A mismatch raises error and bad-checksum on the following cycle, and unexpected-character stays low.
- R7: Once a fault flag is set, it holds while the link state is not idle. Checking stops at the first fault, so later characters change neither flag.
- R8: An idle link state clears all flags, the position and the multiframe count on the next edge. The configuration record is kept.
- R9: finished is high on the cycle after a user-data-state cycle that follows four complete, fault-free multiframes. It stays low when any fault was flagged.
- R10: The multiframe length follows mf_len. Positions after octet 13 and before the closing marker are not captured into the record.
- R11: Characters received in the synchronisation or user data states, such as K-flagged 0xBC, raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| mf_len | input | 9 | Multiframe length in characters |
| link_state | input | 2 | Link state: 0 idle, 1 sync, 2 alignment, 3 data |
| sym_is_k | input | 1 | Character is a control character |
| sym_disp_err | input | 1 | Running disparity error on this character |
| sym_nit | input | 1 | Character was not found in the code table |
| sym_val | input | 8 | Decoded character value |
| cfg_o | output | 87 | Captured configuration record (lane_cfg_t) |
| finished_o | output | 1 | Clean sequence completed and link in data |
| error_o | output | 1 | Any fault seen (sticky) |
| bad_chk_o | output | 1 | Configuration checksum mismatch (sticky) |
| unexp_o | output | 1 | Framing or character fault (sticky) |

## Verification
Two complete clean sequences are run: one with 16-character multiframes and one with 20-character multiframes. The longer one puts nonzero filler after the checksum octet, so a capture that runs past octet 13 is caught. The two configurations differ in every field and set the unused octet bits, which separates a correct unpack from a shifted or unmasked one. The fault patterns are a start marker out of place, a closing marker out of place, a missing closing marker, a stray control character, a disparity-flagged character and a corrupted checksum. Together they separate framing faults from checksum faults and test that each fault stays sticky until the link is idle. A reset in the middle of a run shows that reset, unlike the idle state, also clears the record.

// File: rtl/alnseq_pkg.sv
`timescale 1ns/1ps
package alnseq_pkg;

    localparam logic [7:0] K_R_VAL    = 8'h1C;
    localparam logic [7:0] K_A_VAL    = 8'h7C;
    localparam int         CFG_OCTETS = 14;

    typedef enum logic [1:0] {
        LNK_INIT  = 2'd0,
        LNK_CGS   = 2'd1,
        LNK_ALIGN = 2'd2,
        LNK_DATA  = 2'd3
    } lnk_state_e;

    typedef struct packed {
        logic       is_k;
        logic       disp_err;
        logic       nit;
        logic [7:0] val;
    } sym_t;

    typedef struct packed {
        logic [7:0] dev_id;
        logic [3:0] adj_cnt;
        logic [3:0] bank_id;
        logic       adj_dir;
        logic       phase_adj;
        logic [4:0] lane_id;
        logic       scr_en;
        logic [4:0] lanes;
        logic [7:0] octets;
        logic [4:0] frames;
        logic [7:0] convs;
        logic [1:0] cs_bits;
        logic [4:0] res_bits;
        logic [2:0] subclass;
        logic [4:0] res_prime;
        logic [2:0] version;
        logic [4:0] samples;
        logic       hi_dens;
        logic [4:0] ctrl_words;
        logic [7:0] chk;
    } lane_cfg_t;

    localparam int CFG_W = $bits(lane_cfg_t);

    function automatic logic sym_is(input sym_t s, input logic [7:0] code);
        return s.is_k && (s.val == code);
    endfunction

    function automatic logic [7:0] cfg_sum(input lane_cfg_t c);
        logic [7:0] s;
        s = c.dev_id;
        s += 8'(c.adj_cnt);
        s += 8'(c.bank_id);
        s += 8'(c.adj_dir);
        s += 8'(c.phase_adj);
        s += 8'(c.lane_id);
        s += 8'(c.scr_en);
        s += 8'(c.lanes);
        s += c.octets;
        s += 8'(c.frames);
        s += c.convs;
        s += 8'(c.cs_bits);
        s += 8'(c.res_bits);
        s += 8'(c.subclass);
        s += 8'(c.res_prime);
        s += 8'(c.version);
        s += 8'(c.samples);
        s += 8'(c.hi_dens);
        s += 8'(c.ctrl_words);
        return s;
    endfunction

endpackage

// File: rtl/alnseq_framer.sv
`timescale 1ns/1ps
module alnseq_framer
    import alnseq_pkg::*;
#(
    parameter int LEN_W  = 9,
    parameter int NUM_MF = 4,
    parameter int CFG_MF = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lnk_state_e           state,
    input  logic [LEN_W-1:0]     mf_len,
    input  sym_t                 sym,
    input  logic                 halt,
    output logic                 unexp_hit,
    output logic                 oct_we,
    output logic [$clog2(CFG_OCTETS)-1:0] oct_idx,
    output logic                 cfg_close,
    output logic                 seq_done
);
    localparam int MF_W  = (NUM_MF > 1) ? $clog2(NUM_MF) : 1;
    localparam int IDX_W = $clog2(CFG_OCTETS);

    logic [LEN_W-1:0] pos_q;
    logic [MF_W-1:0]  mf_q;
    logic             done_q;

    logic             active;
    logic             at_first;
    logic             at_last;
    logic             bad_sym;
    logic             good;
    logic             in_cfg_mf;
    logic [LEN_W-1:0] pos_m1;

    always_comb begin
        active   = (state == LNK_ALIGN) && !halt && !done_q;
        at_first = (pos_q == '0);
        at_last  = (pos_q == (mf_len - LEN_W'(1)));
        pos_m1   = pos_q - LEN_W'(1);
        if (sym.disp_err || sym.nit) begin
            bad_sym = 1'b1;
        end else if (at_first) begin
            bad_sym = !sym_is(sym, K_R_VAL);
        end else if (at_last) begin
            bad_sym = !sym_is(sym, K_A_VAL);
        end else begin
            bad_sym = sym.is_k;
        end
    end

    assign good      = active && !bad_sym;
    assign unexp_hit = active && bad_sym;
    assign in_cfg_mf = (mf_q == MF_W'(CFG_MF));
    assign oct_we    = good && in_cfg_mf && !at_first && !at_last
                       && (pos_m1 < LEN_W'(CFG_OCTETS));
    assign oct_idx   = pos_m1[IDX_W-1:0];
    assign cfg_close = good && in_cfg_mf && at_last;
    assign seq_done  = done_q;

    always_ff @(posedge clk) begin
        if (rst || state == LNK_INIT) begin
            pos_q  <= '0;
            mf_q   <= '0;
            done_q <= 1'b0;
        end else if (good) begin
            if (at_last) begin
                pos_q <= '0;
                if (mf_q == MF_W'(NUM_MF - 1)) begin
                    done_q <= 1'b1;
                end else begin
                    mf_q <= mf_q + 1'b1;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // R2
    done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(sym.is_k && sym.val == K_A_VAL));

    // R10
    pos_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_ALIGN) |-> (pos_q < mf_len));

endmodule

// File: rtl/alnseq_cfgcap.sv
`timescale 1ns/1ps
module alnseq_cfgcap
    import alnseq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          oct_we,
    input  logic [$clog2(CFG_OCTETS)-1:0] oct_idx,
    input  logic [7:0]                    oct_val,
    input  logic                          cfg_close,
    output lane_cfg_t                     cfg_o,
    output logic                          chk_bad
);
    lane_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (oct_we) begin
            case (oct_idx)
                0: cfg_q.dev_id <= oct_val;
                1: begin
                    cfg_q.adj_cnt <= oct_val[7:4];
                    cfg_q.bank_id <= oct_val[3:0];
                end
                2: begin
                    cfg_q.adj_dir   <= oct_val[6];
                    cfg_q.phase_adj <= oct_val[5];
                    cfg_q.lane_id   <= oct_val[4:0];
                end
                3: begin
                    cfg_q.scr_en <= oct_val[7];
                    cfg_q.lanes  <= oct_val[4:0];
                end
                4: cfg_q.octets <= oct_val;
                5: cfg_q.frames <= oct_val[4:0];
                6: cfg_q.convs  <= oct_val;
                7: begin
                    cfg_q.cs_bits  <= oct_val[7:6];
                    cfg_q.res_bits <= oct_val[4:0];
                end
                8: begin
                    cfg_q.subclass  <= oct_val[7:5];
                    cfg_q.res_prime <= oct_val[4:0];
                end
                9: begin
                    cfg_q.version <= oct_val[7:5];
                    cfg_q.samples <= oct_val[4:0];
                end
                10: begin
                    cfg_q.hi_dens    <= oct_val[7];
                    cfg_q.ctrl_words <= oct_val[4:0];
                end
                13: cfg_q.chk <= oct_val;
                default: ;
            endcase
        end
    end

    assign cfg_o   = cfg_q;
    assign chk_bad = cfg_close && (cfg_sum(cfg_q) != cfg_q.chk);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !oct_we |=> $stable(cfg_q));

    // R6
    sum_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        chk_bad |-> !oct_we);

endmodule

// File: rtl/alnseq_flags.sv
`timescale 1ns/1ps
module alnseq_flags
    import alnseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lnk_state_e state,
    input  logic       unexp_hit,
    input  logic       chk_bad,
    input  logic       seq_done,
    output logic       unexp_q,
    output logic       badchk_q,
    output logic       fin_q,
    output logic       halt
);
    always_ff @(posedge clk) begin
        if (rst || state == LNK_INIT) begin
            unexp_q  <= 1'b0;
            badchk_q <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            if (unexp_hit) unexp_q  <= 1'b1;
            if (chk_bad)   badchk_q <= 1'b1;
            fin_q <= (state == LNK_DATA) && seq_done && !unexp_q && !badchk_q;
        end
    end

    assign halt = unexp_q || badchk_q;

    // R7
    unexp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unexp_q && state != LNK_INIT) |=> unexp_q);

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_INIT) |=> (!unexp_q && !badchk_q && !fin_q));

    // R6
    sum_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(badchk_q) |-> !unexp_q);

    // R9
    fin_clean_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (!unexp_q && !badchk_q));

endmodule

// File: rtl/alnseq_parser.sv
`timescale 1ns/1ps
module alnseq_parser
    import alnseq_pkg::*;
#(
    parameter int LEN_W  = 9,
    parameter int NUM_MF = 4,
    parameter int CFG_MF = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] mf_len,
    input  logic [1:0]       link_state,
    input  logic             sym_is_k,
    input  logic             sym_disp_err,
    input  logic             sym_nit,
    input  logic [7:0]       sym_val,
    output logic [CFG_W-1:0] cfg_o,
    output logic             finished_o,
    output logic             error_o,
    output logic             bad_chk_o,
    output logic             unexp_o
);
    localparam int IDX_W = $clog2(CFG_OCTETS);

    lnk_state_e       state;
    sym_t             sym;
    logic             halt;
    logic             unexp_hit;
    logic             oct_we;
    logic [IDX_W-1:0] oct_idx;
    logic             cfg_close;
    logic             seq_done;
    logic             chk_bad;
    lane_cfg_t        cfg;

    assign state = lnk_state_e'(link_state);
    assign sym   = '{is_k: sym_is_k, disp_err: sym_disp_err, nit: sym_nit, val: sym_val};

    alnseq_framer #(
        .LEN_W (LEN_W),
        .NUM_MF(NUM_MF),
        .CFG_MF(CFG_MF)
    ) framer_i (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .mf_len   (mf_len),
        .sym      (sym),
        .halt     (halt),
        .unexp_hit(unexp_hit),
        .oct_we   (oct_we),
        .oct_idx  (oct_idx),
        .cfg_close(cfg_close),
        .seq_done (seq_done)
    );

    alnseq_cfgcap cfgcap_i (
        .clk      (clk),
        .rst      (rst),
        .oct_we   (oct_we),
        .oct_idx  (oct_idx),
        .oct_val  (sym_val),
        .cfg_close(cfg_close),
        .cfg_o    (cfg),
        .chk_bad  (chk_bad)
    );

    alnseq_flags flags_i (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .unexp_hit(unexp_hit),
        .chk_bad  (chk_bad),
        .seq_done (seq_done),
        .unexp_q  (unexp_o),
        .badchk_q (bad_chk_o),
        .fin_q    (finished_o),
        .halt     (halt)
    );

    assign cfg_o   = cfg;
    assign error_o = halt;

endmodule

// File: tb/alnseq_parser_tb_top.sv
`timescale 1ns/1ps
module alnseq_parser_tb_top;
    import alnseq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [8:0]       mf_len = 9'd16;
    logic [1:0]       link_state = 2'd0;
    logic             sym_is_k = 1'b0;
    logic             sym_disp_err = 1'b0;
    logic             sym_nit = 1'b0;
    logic [7:0]       sym_val = 8'h00;
    logic [CFG_W-1:0] cfg_o;
    logic             finished_o, error_o, bad_chk_o, unexp_o;

    int n_checks = 0;
    int n_bad    = 0;

    always #2.5 clk = ~clk;

    alnseq_parser dut_i (
        .clk(clk), .rst(rst), .mf_len(mf_len), .link_state(link_state),
        .sym_is_k(sym_is_k), .sym_disp_err(sym_disp_err), .sym_nit(sym_nit),
        .sym_val(sym_val), .cfg_o(cfg_o), .finished_o(finished_o),
        .error_o(error_o), .bad_chk_o(bad_chk_o), .unexp_o(unexp_o)
    );

    typedef struct {
        logic      unexp;
        logic      bad;
        logic      fin;
        logic      cfg_en;
        lane_cfg_t cfg;
        string     tag;
    } exp_t;

    exp_t exp_q[$];

    // Driver: apply one character at a falling edge, queue the result due after the next rising edge
    task automatic drive(input lnk_state_e st, input logic k, input logic [7:0] v,
                         input logic dsp, input logic nt,
                         input logic e_un, input logic e_bad, input logic e_fin,
                         input logic c_en, input lane_cfg_t c, input string tag);
        exp_t e;
        @(negedge clk);
        link_state   = st;
        sym_is_k     = k;
        sym_val      = v;
        sym_disp_err = dsp;
        sym_nit      = nt;
        e.unexp = e_un; e.bad = e_bad; e.fin = e_fin;
        e.cfg_en = c_en; e.cfg = c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each queued item 2 ns after the rising edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if ({unexp_o, bad_chk_o, error_o, finished_o} !==
                    {e.unexp, e.bad, e.unexp | e.bad, e.fin}) begin
                    n_bad++;
                    $display("FAIL %s: flags unexp/bad/err/fin got %b%b%b%b exp %b%b%b%b",
                             e.tag, unexp_o, bad_chk_o, error_o, finished_o,
                             e.unexp, e.bad, e.unexp | e.bad, e.fin);
                end
                if (e.cfg_en) begin
                    n_checks++;
                    if (cfg_o !== CFG_W'(e.cfg)) begin
                        n_bad++;
                        $display("FAIL %s: cfg got %h exp %h", e.tag, cfg_o, e.cfg);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] ref_sum(input lane_cfg_t c);
        int s;
        s = int'(c.dev_id) + int'(c.octets) + int'(c.convs)
          + int'(c.adj_cnt) + int'(c.bank_id) + int'(c.lane_id) + int'(c.lanes)
          + int'(c.frames) + int'(c.res_bits) + int'(c.res_prime) + int'(c.samples)
          + int'(c.ctrl_words) + int'(c.cs_bits) + int'(c.subclass) + int'(c.version)
          + int'(c.adj_dir) + int'(c.phase_adj) + int'(c.scr_en) + int'(c.hi_dens);
        return s[7:0];
    endfunction

    // Octet layout per R4; unused bits deliberately set to prove they are ignored
    task automatic encode(input lane_cfg_t c, output logic [7:0] o [CFG_OCTETS]);
        o[0]  = c.dev_id;
        o[1]  = {c.adj_cnt, c.bank_id};
        o[2]  = {1'b1, c.adj_dir, c.phase_adj, c.lane_id};
        o[3]  = {c.scr_en, 2'b11, c.lanes};
        o[4]  = c.octets;
        o[5]  = {3'b101, c.frames};
        o[6]  = c.convs;
        o[7]  = {c.cs_bits, 1'b1, c.res_bits};
        o[8]  = {c.subclass, c.res_prime};
        o[9]  = {c.version, c.samples};
        o[10] = {c.hi_dens, 2'b10, c.ctrl_words};
        o[11] = 8'hFF;
        o[12] = 8'h5A;
        o[13] = c.chk;
    endtask

    // One clean multiframe: start marker, body, closing marker
    task automatic send_mf(input int len, input logic is_cfg, input logic [7:0] o [CFG_OCTETS],
                           input logic e_bad, input lane_cfg_t expc, input string tag);
        lane_cfg_t z = '0;
        drive(LNK_ALIGN, 1'b1, K_R_VAL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, tag);
        for (int i = 1; i < len - 1; i++) begin
            logic [7:0] v;
            if (is_cfg && i - 1 < CFG_OCTETS) v = o[i-1];
            else if (is_cfg) v = 8'hE7;
            else v = 8'(i * 3);
            drive(LNK_ALIGN, 1'b0, v, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, tag);
        end
        drive(LNK_ALIGN, 1'b1, K_A_VAL, 1'b0, 1'b0, 1'b0, e_bad, 1'b0, is_cfg, expc, tag);
    endtask

    task automatic idle_sync(input string tag);
        lane_cfg_t z = '0;
        drive(LNK_INIT, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, tag);
        for (int i = 0; i < 3; i++)
            drive(LNK_CGS, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, "R11 sync chars");
    endtask

    // Start marker, then n fillers, then the faulting character; expect unexp afterwards
    task automatic fault_run(input int n, input logic k, input logic [7:0] v,
                             input logic dsp, input logic nt, input string tag);
        lane_cfg_t z = '0;
        idle_sync(tag);
        drive(LNK_ALIGN, 1'b1, K_R_VAL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, tag);
        for (int i = 0; i < n; i++)
            drive(LNK_ALIGN, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, tag);
        drive(LNK_ALIGN, k, v, dsp, nt, 1'b1, 1'b0, 1'b0, 1'b0, z, tag);
        drive(LNK_ALIGN, 1'b1, K_A_VAL, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, z, "R7 sticky");
        drive(LNK_ALIGN, 1'b1, K_R_VAL, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, z, "R7 sticky");
        drive(LNK_DATA, 1'b0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, z, "R9 no finish on fault");
        drive(LNK_INIT, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, z, "R8 idle clears");
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        lane_cfg_t z = '0;
        lane_cfg_t ca, cb, cbad;
        logic [7:0] oa [CFG_OCTETS];
        logic [7:0] ob [CFG_OCTETS];
        logic [7:0] obad [CFG_OCTETS];

        ca = '{dev_id: 8'hAA, adj_cnt: 4'd7, bank_id: 4'd14, adj_dir: 1'b1, phase_adj: 1'b0,
               lane_id: 5'd10, scr_en: 1'b1, lanes: 5'd30, octets: 8'd204, frames: 5'd31,
               convs: 8'd51, cs_bits: 2'd2, res_bits: 5'd3, subclass: 3'd1, res_prime: 5'd29,
               version: 3'd0, samples: 5'd0, hi_dens: 1'b0, ctrl_words: 5'd0, chk: 8'h00};
        ca.chk = ref_sum(ca);
        cb = '{dev_id: 8'h35, adj_cnt: 4'd2, bank_id: 4'd5, adj_dir: 1'b0, phase_adj: 1'b1,
               lane_id: 5'd3, scr_en: 1'b0, lanes: 5'd1, octets: 8'd2, frames: 5'd15,
               convs: 8'd4, cs_bits: 2'd1, res_bits: 5'd15, subclass: 3'd2, res_prime: 5'd16,
               version: 3'd1, samples: 5'd1, hi_dens: 1'b1, ctrl_words: 5'd2, chk: 8'h00};
        cb.chk = ref_sum(cb);
        cbad = ca;
        cbad.chk = ca.chk + 8'd1;
        encode(ca, oa);
        encode(cb, ob);
        encode(cbad, obad);

        // R1: reset state
        drive(LNK_INIT, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, z, "R1 reset state");
        rst = 1'b0;

        // R2 R4 R5 R9 R11: clean sequence, length 16
        idle_sync("R11 idle");
        send_mf(16, 1'b0, oa, 1'b0, z, "R2 mf0");
        send_mf(16, 1'b1, oa, 1'b0, ca, "R4 config capture");
        send_mf(16, 1'b0, oa, 1'b0, ca, "R2 mf2");
        send_mf(16, 1'b0, oa, 1'b0, ca, "R2 mf3");
        drive(LNK_DATA, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, z, "R9 finished");
        drive(LNK_DATA, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ca, "R5 cfg held in data");
        drive(LNK_INIT, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ca, "R8 idle keeps cfg");

        // R2: misplaced start marker, misplaced closing marker, missing closing marker
        fault_run(2, 1'b1, K_R_VAL, 1'b0, 1'b0, "R2 start marker out of place");
        fault_run(2, 1'b1, K_A_VAL, 1'b0, 1'b0, "R2 closing marker out of place");
        fault_run(14, 1'b0, 8'h7C, 1'b0, 1'b0, "R2 closing marker missing");
        // R3: stray control, disparity flag, not-in-table flag
        fault_run(1, 1'b1, 8'hBC, 1'b0, 1'b0, "R3 stray control char");
        fault_run(3, 1'b0, 8'h22, 1'b1, 1'b0, "R3 disparity flag");
        fault_run(0, 1'b0, 8'h22, 1'b0, 1'b1, "R3 not-in-table flag");

        // R6 R7: checksum mismatch, then a misplaced marker must not raise unexp
        idle_sync("R6 idle");
        send_mf(16, 1'b0, obad, 1'b0, z, "R6 mf0");
        send_mf(16, 1'b1, obad, 1'b1, cbad, "R6 bad checksum");
        drive(LNK_ALIGN, 1'b1, K_A_VAL, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, z, "R7 frozen after checksum fault");
        drive(LNK_ALIGN, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, z, "R7 frozen after checksum fault");
        drive(LNK_DATA, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, z, "R9 no finish on bad checksum");
        drive(LNK_INIT, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, cbad, "R8 idle clears bad checksum");

        // R10: length 20, filler after the checksum octet ignored
        mf_len = 9'd20;
        idle_sync("R10 idle");
        send_mf(20, 1'b0, ob, 1'b0, z, "R10 mf0");
        send_mf(20, 1'b1, ob, 1'b0, cb, "R10 config with filler");
        send_mf(20, 1'b0, ob, 1'b0, cb, "R10 mf2");
        send_mf(20, 1'b0, ob, 1'b0, cb, "R10 mf3");
        drive(LNK_DATA, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, cb, "R10 finished");

        // R1: reset in the middle of data clears flags and record
        drive(LNK_DATA, 1'b0, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, z, "R1 reset clears all");
        rst = 1'b1;
        drive(LNK_DATA, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, z, "R1 reset held");
        rst = 1'b1;

        wait (exp_q.size() == 0);
        @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule